// File: doc/BRIEF.md
# Programmable Parallel Expansion Bus Controller

This block turns single internal read and write requests into cycles on an external asynchronous parallel bus with eight chip selects. A request names a chip-select index, a byte offset inside that bank, a two-bit byte enable and, for writes, sixteen bits of write data. The controller runs one external cycle at a time. It drives the active-low chip selects, the address pins, the data pins with their output enable, and the strobes. It then returns a single-cycle response that carries read data or an error flag.

Every chip select has its own configuration word, written through a small register port. The word sets five phase extensions, the strobe style, an 8-bit data width, write permission, permission for byte reads on 16-bit devices, and address/data multiplexing. A configuration word has bits [1:0] address extension A, [3:2] setup extension S, [7:4] strobe extension T, [9:8] hold extension H, [13:10] recovery extension R, [15:14] cycle type, [16] write enable, [17] byte-read permit, [18] multiplex, [19] narrow (8-bit). Illegal requests are answered with an error response and cause no bus activity.

Top module: `exp_bus_ctrl`

## Requirements
- R1: An accepted legal request runs these phases in order: address (1+A cycles, all chip selects high), setup, strobe and hold (together 3+S+T+H cycles with the selected chip select low), then recovery (1+R cycles, chip selects high). rsp_valid_o is high in the cycle after recovery, which is cycle 6+A+S+T+H+R counting the first address cycle as 1.
- R2: The strobe is low for exactly 1+T consecutive cycles, and only while a chip select is low.
- R3: Cycle type 0 uses bus_rd_no for reads and bus_wr_no for writes, and bus_ds_no stays high. Cycle type 1 uses bus_ds_no with bus_rnw_o (1 = read, 0 = write), and bus_rd_no and bus_wr_no stay high. Data pins are driven during every write strobe.
- R4: Chip select k drives bus_cs_no to the one-hot active-low value ~(1<<k), and no two chip selects are ever low together. Each index has its own configuration word, written with cfg_we_i at cfg_idx_i and read back on cfg_rdata_o at cfg_idx_i.
- R5: A write to a chip select whose write-enable bit is 0 returns rsp_err_o=1 with rsp_valid_o in the cycle after acceptance, and no chip select or strobe goes low.
- R6: Cycle types 2 and 3 are rejected in the same way as in R5, for reads and for writes.
- R7: On a 16-bit device (narrow=0), a read with byte enable 01 or 10 is rejected as in R5 when the byte-read permit is 0. When the permit is 1, the read runs normally.
- R8: On a narrow device only data pins [7:0] carry data. A write drives wdata[15:8] when byte enable is 10 and wdata[7:0] otherwise, with pins [15:8] at 0. A read returns the pin [7:0] byte in every lane that is enabled.
- R9: With multiplex set, the data pins carry offset bits [15:0] with output enable high during the address phase. Without it, a read leaves the output enable low in that phase.
- R10: Read data is taken from the pins in the last strobe cycle. rsp_rdata_o holds pins [15:8] in the upper lane and [7:0] in the lower lane, with a lane forced to 0 when its byte-enable bit is 0. Writes and errors return 0.
- R11: req_ready_o is low from acceptance until recovery ends. A configuration write during a cycle does not change the timing of that cycle.
- R12: After reset, all chip selects and strobes are high, req_ready_o is 1, rsp_valid_o is 0, and every configuration word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | CSW | Configuration index for write and readback |
| cfg_wdata_i | input | 20 | Configuration word to write |
| cfg_rdata_o | output | 20 | Configuration word at cfg_idx_i |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CSW | Chip-select index |
| req_off_i | input | AW | Byte offset in the bank |
| req_be_i | input | 2 | Byte enables (bit 1 upper lane) |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Single-cycle response |
| rsp_err_o | output | 1 | Request rejected |
| rsp_rdata_o | output | 16 | Read data |
| bus_cs_no | output | NUM_CS | Chip selects, active low |
| bus_addr_o | output | AW | Address pins |
| bus_data_o | output | 16 | Data pins, driven value |
| bus_data_oe_o | output | 1 | Data pin output enable |
| bus_data_i | input | 16 | Data pins, sampled value |
| bus_rd_no | output | 1 | Read strobe, active low (type 0) |
| bus_wr_no | output | 1 | Write strobe, active low (type 0) |
| bus_ds_no | output | 1 | Data strobe, active low (type 1) |
| bus_rnw_o | output | 1 | Direction, 1 = read (type 1) |

## Verification
The assertions assume that reset is applied before the first request. They also assume that request fields matter only in the cycle where req_valid_i and req_ready_o are both high. Under those conditions they check chip-select exclusivity, strobe containment, the error-response timing and the strobe-length bound for any mix of configurations. The stimulus raises req_valid_i for exactly one accepted cycle and waits for req_ready_o before the next request. It changes a configuration word mid-cycle only in the snapshot test, where the checks expect the old timing.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int DW = 16;

  typedef struct packed {
    logic       narrow;
    logic       mux_en;
    logic       byte_rd_ok;
    logic       wr_en;
    logic [1:0] cyc_type;
    logic [3:0] recov_ext;
    logic [1:0] hold_ext;
    logic [3:0] strobe_ext;
    logic [1:0] setup_ext;
    logic [1:0] addr_ext;
  } cs_cfg_t;

  localparam int CFGW = $bits(cs_cfg_t);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_e;

  localparam logic [1:0] CT_SEP = 2'd0;
  localparam logic [1:0] CT_DS  = 2'd1;

  function automatic logic req_illegal(cs_cfg_t c, logic wr, logic [1:0] be);
    logic byte_rd;
    byte_rd = !wr && !c.narrow && (be == 2'b01 || be == 2'b10);
    return (wr && !c.wr_en) || c.cyc_type[1] || (byte_rd && !c.byte_rd_ok);
  endfunction
endpackage

// File: rtl/ebc_cfg_regs.sv
module ebc_cfg_regs
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [CSW-1:0] idx_i,
  input  cs_cfg_t        wdata_i,
  input  logic [CSW-1:0] req_idx_i,
  output cs_cfg_t        rd_o,
  output cs_cfg_t        req_cfg_o
);
  cs_cfg_t cfg_q [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[i] <= '0;
      else if (we_i && idx_i == CSW'(i)) cfg_q[i] <= wdata_i;
    end
  end

  assign rd_o      = cfg_q[idx_i];
  assign req_cfg_o = cfg_q[req_idx_i];
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] start_addr_ext_i,
  input  cs_cfg_t    cfg_i,
  output phase_e     phase_o,
  output logic       smp_o,
  output logic       done_o
);
  phase_e     phase_q;
  logic [3:0] cnt_q;
  logic       last;

  assign last    = (cnt_q == 4'd0);
  assign phase_o = phase_q;
  assign smp_o   = (phase_q == PH_STROBE) && last;
  assign done_o  = (phase_q == PH_RECOV) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_ADDR;
          cnt_q   <= {2'b00, start_addr_ext_i};
        end
        PH_ADDR: if (last) begin
          phase_q <= PH_SETUP;
          cnt_q   <= {2'b00, cfg_i.setup_ext};
        end else cnt_q <= cnt_q - 4'd1;
        PH_SETUP: if (last) begin
          phase_q <= PH_STROBE;
          cnt_q   <= cfg_i.strobe_ext;
        end else cnt_q <= cnt_q - 4'd1;
        PH_STROBE: if (last) begin
          phase_q <= PH_HOLD;
          cnt_q   <= {2'b00, cfg_i.hold_ext};
        end else cnt_q <= cnt_q - 4'd1;
        PH_HOLD: if (last) begin
          phase_q <= PH_RECOV;
          cnt_q   <= cfg_i.recov_ext;
        end else cnt_q <= cnt_q - 4'd1;
        PH_RECOV: if (last) phase_q <= PH_IDLE;
                  else cnt_q <= cnt_q - 4'd1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int AW = 24,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  phase_e          phase_i,
  input  cs_cfg_t         cfg_i,
  input  logic [CSW-1:0]  cs_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   off_i,
  input  logic [1:0]      be_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   bus_data_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o,
  output logic            data_oe_o,
  output logic            rd_no,
  output logic            wr_no,
  output logic            ds_no,
  output logic            rnw_o,
  output logic [DW-1:0]   rdata_o
);
  logic          cs_win, stb_on, act;
  logic [31:0]   off_ext;
  logic [DW-1:0] wlane;
  logic [7:0]    lo_b, hi_b;

  assign cs_win  = (phase_i == PH_SETUP) || (phase_i == PH_STROBE) || (phase_i == PH_HOLD);
  assign stb_on  = (phase_i == PH_STROBE);
  assign act     = cs_win || (phase_i == PH_ADDR);
  assign off_ext = 32'(off_i);
  assign addr_o  = off_i;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_no[i] = !(cs_win && cs_i == CSW'(i));
  end

  always_comb begin
    rd_no = 1'b1;
    wr_no = 1'b1;
    ds_no = 1'b1;
    rnw_o = 1'b1;
    if (cfg_i.cyc_type == CT_DS) begin
      ds_no = !stb_on;
      rnw_o = !(act && wr_i);
    end else if (cfg_i.cyc_type == CT_SEP) begin
      rd_no = !(stb_on && !wr_i);
      wr_no = !(stb_on && wr_i);
    end
  end

  always_comb begin
    if (cfg_i.narrow)
      wlane = {8'h00, (be_i == 2'b10) ? wdata_i[15:8] : wdata_i[7:0]};
    else
      wlane = wdata_i;
  end

  always_comb begin
    data_o    = '0;
    data_oe_o = 1'b0;
    if (phase_i == PH_ADDR && cfg_i.mux_en) begin
      data_o    = off_ext[DW-1:0];
      data_oe_o = 1'b1;
    end else if (cs_win && wr_i) begin
      data_o    = wlane;
      data_oe_o = 1'b1;
    end
  end

  assign lo_b    = bus_data_i[7:0];
  assign hi_b    = cfg_i.narrow ? bus_data_i[7:0] : bus_data_i[15:8];
  assign rdata_o = {be_i[1] ? hi_b : 8'h00, be_i[0] ? lo_b : 8'h00};
endmodule

// File: rtl/exp_bus_ctrl.sv
module exp_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int AW = 24,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CSW-1:0]    cfg_idx_i,
  input  logic [CFGW-1:0]   cfg_wdata_i,
  output logic [CFGW-1:0]   cfg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [CSW-1:0]    req_cs_i,
  input  logic [AW-1:0]     req_off_i,
  input  logic [1:0]        req_be_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic [NUM_CS-1:0] bus_cs_no,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DW-1:0]     bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DW-1:0]     bus_data_i,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic              bus_ds_no,
  output logic              bus_rnw_o
);
  cs_cfg_t        cfg_rd, cfg_req, cur_cfg_q;
  phase_e         phase;
  logic           smp, done, accept, illegal, start;
  logic [CSW-1:0] cs_q;
  logic           wr_q;
  logic [AW-1:0]  off_q;
  logic [1:0]     be_q;
  logic [DW-1:0]  wdata_q, rdata_q, rdata_fmt;
  logic           rsp_valid_q, rsp_err_q;

  ebc_cfg_regs #(.NUM_CS(NUM_CS)) u_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .idx_i     (cfg_idx_i),
    .wdata_i   (cs_cfg_t'(cfg_wdata_i)),
    .req_idx_i (req_cs_i),
    .rd_o      (cfg_rd),
    .req_cfg_o (cfg_req)
  );

  assign cfg_rdata_o = cfg_rd;
  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign illegal     = req_illegal(cfg_req, req_write_i, req_be_i);
  assign start       = accept && !illegal;

  ebc_seq u_seq (
    .clk_i, .rst_ni,
    .start_i          (start),
    .start_addr_ext_i (cfg_req.addr_ext),
    .cfg_i            (cur_cfg_q),
    .phase_o          (phase),
    .smp_o            (smp),
    .done_o           (done)
  );

  ebc_pins #(.NUM_CS(NUM_CS), .AW(AW)) u_pins (
    .phase_i    (phase),
    .cfg_i      (cur_cfg_q),
    .cs_i       (cs_q),
    .wr_i       (wr_q),
    .off_i      (off_q),
    .be_i       (be_q),
    .wdata_i    (wdata_q),
    .bus_data_i (bus_data_i),
    .cs_no      (bus_cs_no),
    .addr_o     (bus_addr_o),
    .data_o     (bus_data_o),
    .data_oe_o  (bus_data_oe_o),
    .rd_no      (bus_rd_no),
    .wr_no      (bus_wr_no),
    .ds_no      (bus_ds_no),
    .rnw_o      (bus_rnw_o),
    .rdata_o    (rdata_fmt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_cfg_q   <= '0;
      cs_q        <= '0;
      wr_q        <= 1'b0;
      off_q       <= '0;
      be_q        <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        rdata_q <= '0;
        if (illegal) begin
          rsp_valid_q <= 1'b1;
          rsp_err_q   <= 1'b1;
        end else begin
          cur_cfg_q <= cfg_req;
          cs_q      <= req_cs_i;
          wr_q      <= req_write_i;
          off_q     <= req_off_i;
          be_q      <= req_be_i;
          wdata_q   <= req_wdata_i;
        end
      end
      if (smp && !wr_q) rdata_q <= rdata_fmt;
      if (done) begin
        rsp_valid_q <= 1'b1;
        rsp_err_q   <= 1'b0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/exp_bus_ctrl_chk.sv
module exp_bus_ctrl_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [NUM_CS-1:0] bus_cs_no,
  input logic              bus_data_oe_o,
  input logic              bus_rd_no,
  input logic              bus_wr_no,
  input logic              bus_ds_no,
  input logic              bus_rnw_o
);
  logic       stb_act, cs_any;
  logic [4:0] run_q;

  assign stb_act = !bus_rd_no || !bus_wr_no || !bus_ds_no;
  assign cs_any  = (bus_cs_no != '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (stb_act) run_q <= (run_q == 5'd31) ? run_q : run_q + 5'd1;
    else run_q <= '0;
  end

  assert_cs_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bus_cs_no));

  assert_strobe_in_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_act |-> cs_any);

  assert_strobe_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_act |-> (run_q < 5'd16));

  assert_busy_not_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_any |-> !req_ready_o);

  assert_rsp_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  assert_err_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> $past(req_valid_i && req_ready_o && !cs_any));

  assert_sep_strobes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_no && !bus_wr_no));

  assert_wr_drives_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_no || (!bus_ds_no && !bus_rnw_o)) |-> bus_data_oe_o);

  assert_rd_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_no || (!bus_ds_no && bus_rnw_o)) |-> !bus_data_oe_o);
endmodule

bind exp_bus_ctrl exp_bus_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_err_o     (rsp_err_o),
  .bus_cs_no     (bus_cs_no),
  .bus_data_oe_o (bus_data_oe_o),
  .bus_rd_no     (bus_rd_no),
  .bus_wr_no     (bus_wr_no),
  .bus_ds_no     (bus_ds_no),
  .bus_rnw_o     (bus_rnw_o)
);

// File: tb/exp_bus_ctrl_test.sv
module exp_bus_ctrl_test;
  localparam int NCS = 8;
  localparam int AW = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [19:0] cfg_wdata = '0;
  logic [19:0] cfg_rdata;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [AW-1:0] req_off = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [NCS-1:0] bus_cs_n;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_dout, bus_din;
  logic        bus_oe, bus_rd_n, bus_wr_n, bus_ds_n, bus_rnw;

  int checks = 0;
  int fails = 0;
  logic [19:0] cfgm [NCS];
  logic [16:0] expq [$];
  string       tagq [$];

  always #5 clk = ~clk;

  exp_bus_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_cs_i(req_cs), .req_off_i(req_off), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .bus_cs_no(bus_cs_n), .bus_addr_o(bus_addr), .bus_data_o(bus_dout),
    .bus_data_oe_o(bus_oe), .bus_data_i(bus_din),
    .bus_rd_no(bus_rd_n), .bus_wr_no(bus_wr_n), .bus_ds_no(bus_ds_n), .bus_rnw_o(bus_rnw)
  );

  // device model: pattern only while a read strobe is active
  assign bus_din = (!bus_rd_n || (!bus_ds_n && bus_rnw)) ? (bus_addr[15:0] ^ 16'hA5C3) : 16'hDEAD;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(int a, int s, int t, int h, int r, int ct,
                                     bit we, bit bro, bit mux, bit nar);
    return {nar, mux, bro, we, 2'(ct), 4'(r), 2'(h), 4'(t), 2'(s), 2'(a)};
  endfunction

  task automatic set_cfg(input int idx, input logic [19:0] w);
    @(negedge clk);
    cfg_idx = 3'(idx); cfg_wdata = w; cfg_we = 1'b1;
    cfgm[idx] = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // monitor: pop expected responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R10 unexpected rsp", 1, 0);
      else begin
        logic [16:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(rsp_err == e[16], {t, " err"}, int'(rsp_err), int'(e[16]));
        chk(rsp_rdata == e[15:0], {t, " rdata"}, int'(rsp_rdata), int'(e[15:0]));
      end
    end
  end

  task automatic run(input bit wr, input int cs, input logic [AW-1:0] off,
                     input logic [1:0] be, input logic [15:0] wd, input string tag);
    logic [19:0] c;
    int a, s, t, h, r, ct;
    bit nar, mux, err;
    logic [15:0] p, exp_rd, exp_wd;
    int k, rsp_k, cs_cnt, first_cs, stb_cnt, bad_stb, bad_cs, bad_rdy, bad_wd;
    c = cfgm[cs];
    a = int'(c[1:0]); s = int'(c[3:2]); t = int'(c[7:4]); h = int'(c[9:8]);
    r = int'(c[13:10]); ct = int'(c[15:14]); mux = c[18]; nar = c[19];
    err = (wr && !c[16]) || (ct >= 2) ||
          (!wr && !nar && (be == 2'b01 || be == 2'b10) && !c[17]);
    p = off[15:0] ^ 16'hA5C3;
    exp_rd = {be[1] ? (nar ? p[7:0] : p[15:8]) : 8'h00, be[0] ? p[7:0] : 8'h00};
    if (wr || err) exp_rd = 16'h0;
    exp_wd = nar ? {8'h00, (be == 2'b10) ? wd[15:8] : wd[7:0]} : wd;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = 3'(cs); req_off = off;
    req_be = be; req_wdata = wd;
    @(posedge clk);
    expq.push_back({err, exp_rd});
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_k = 0; cs_cnt = 0; first_cs = 0; stb_cnt = 0;
    bad_stb = 0; bad_cs = 0; bad_rdy = 0; bad_wd = 0;
    for (k = 1; k < 100; k++) begin
      if (k > 1) @(negedge clk);
      if (rsp_valid) begin rsp_k = k; break; end
      if (req_ready) bad_rdy++;
      if (k == 1 && !err) begin
        if (mux) chk(bus_oe && bus_dout == off[15:0], {tag, " R9 mux addr"},
                     int'(bus_dout), int'(off[15:0]));
        else if (!wr) chk(!bus_oe, {tag, " R9 no mux oe"}, int'(bus_oe), 0);
      end
      if (bus_cs_n != '1) begin
        cs_cnt++;
        if (first_cs == 0) first_cs = k;
        if (bus_cs_n != ~(8'(1) << cs)) bad_cs++;
      end
      if (ct == 0) begin
        if ((wr ? !bus_wr_n : !bus_rd_n)) stb_cnt++;
        if ((wr ? !bus_rd_n : !bus_wr_n) || !bus_ds_n) bad_stb++;
      end else begin
        if (!bus_ds_n && (bus_rnw == !wr)) stb_cnt++;
        if (!bus_rd_n || !bus_wr_n || (!bus_ds_n && bus_rnw != !wr)) bad_stb++;
      end
      if (wr && (!bus_wr_n || !bus_ds_n) && !(bus_oe && bus_dout == exp_wd)) bad_wd++;
    end
    if (err) begin
      chk(rsp_k == 1, {tag, " err rsp timing"}, rsp_k, 1);
      chk(cs_cnt == 0 && stb_cnt == 0 && bad_stb == 0, {tag, " err quiet"}, cs_cnt, 0);
    end else begin
      chk(rsp_k == 6 + a + s + t + h + r, {tag, " R1 total"}, rsp_k, 6 + a + s + t + h + r);
      chk(first_cs == 2 + a, {tag, " R1 addr phase"}, first_cs, 2 + a);
      chk(cs_cnt == 3 + s + t + h, {tag, " R1 cs window"}, cs_cnt, 3 + s + t + h);
      chk(bad_cs == 0, {tag, " R4 cs select"}, bad_cs, 0);
      chk(stb_cnt == 1 + t, {tag, " R2 strobe len"}, stb_cnt, 1 + t);
      chk(bad_stb == 0, {tag, " R3 strobe style"}, bad_stb, 0);
      chk(bad_rdy == 0, {tag, " R11 ready low"}, bad_rdy, 0);
      if (wr) chk(bad_wd == 0, {tag, " R8 write data"}, bad_wd, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCS; i++) cfgm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(bus_cs_n == 8'hFF, "R12 cs idle", int'(bus_cs_n), 8'hFF);
    chk(bus_rd_n && bus_wr_n && bus_ds_n, "R12 strobes idle",
        int'({bus_rd_n, bus_wr_n, bus_ds_n}), 7);
    chk(req_ready && !rsp_valid, "R12 ready/rsp", int'({req_ready, rsp_valid}), 2);
    for (int i = 0; i < NCS; i++) begin
      cfg_idx = 3'(i);
      #1 chk(cfg_rdata == 20'h0, "R12 cfg zero", int'(cfg_rdata), 0);
    end

    set_cfg(0, mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    set_cfg(2, mk(3, 2, 5, 1, 4, 1, 1, 0, 0, 0));
    set_cfg(3, mk(1, 0, 2, 2, 1, 0, 1, 0, 1, 1));
    set_cfg(4, mk(0, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    set_cfg(5, mk(0, 0, 0, 0, 0, 2, 1, 1, 0, 0));
    set_cfg(6, mk(0, 0, 0, 0, 0, 3, 1, 1, 0, 0));
    set_cfg(7, mk(2, 3, 3, 3, 2, 0, 1, 0, 1, 0));

    // R4 per-CS readback
    for (int i = 0; i < NCS; i++) begin
      @(negedge clk);
      cfg_idx = 3'(i);
      #1 chk(cfg_rdata == cfgm[i], "R4 cfg readback", int'(cfg_rdata), int'(cfgm[i]));
    end

    run(1, 0, 24'h000102, 2'b11, 16'h1234, "R3 type0 write cs0");
    run(0, 0, 24'h0010F0, 2'b11, 16'h0, "R10 type0 read cs0");
    run(0, 2, 24'h123456, 2'b11, 16'h0, "R3 type1 read cs2");
    run(1, 2, 24'h00ABCD, 2'b11, 16'hBEEF, "R3 type1 write cs2");
    run(1, 3, 24'h000033, 2'b10, 16'hC35A, "R8 narrow write hi lane");
    run(1, 3, 24'h000034, 2'b01, 16'hC35A, "R8 narrow write lo lane");
    run(0, 3, 24'h004321, 2'b10, 16'h0, "R8 narrow read hi lane");
    run(0, 3, 24'h004322, 2'b11, 16'h0, "R8 narrow read both");
    run(1, 4, 24'h000010, 2'b11, 16'h5555, "R5 write disabled");
    run(0, 4, 24'h000010, 2'b11, 16'h0, "R5 read allowed");
    run(0, 5, 24'h000020, 2'b11, 16'h0, "R6 type2 read");
    run(1, 6, 24'h000020, 2'b11, 16'h7777, "R6 type3 write");
    run(0, 7, 24'h000777, 2'b01, 16'h0, "R7 byte read blocked");
    run(0, 7, 24'h00FEDC, 2'b11, 16'h0, "R7 halfword read mux");
    set_cfg(7, mk(2, 3, 3, 3, 2, 0, 1, 1, 1, 0));
    run(0, 7, 24'h000778, 2'b10, 16'h0, "R7 byte read permitted");
    run(0, 7, 24'h000779, 2'b01, 16'h0, "R10 byte read low lane");

    // R11 snapshot: config rewritten mid-cycle
    set_cfg(1, mk(3, 3, 15, 3, 15, 0, 1, 0, 0, 0));
    fork
      run(0, 1, 24'h00AAAA, 2'b11, 16'h0, "R11 snapshot read");
      begin
        repeat (4) @(negedge clk);
        cfg_idx = 3'd1; cfg_wdata = mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    cfgm[1] = mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    run(1, 1, 24'h000005, 2'b11, 16'h0F0F, "R11 new cfg applies");

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R10 all responses seen", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule